// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block lets a system erase an entire parallel NOR-style flash with a single request. When `start_i` is pulsed while the block is idle, it releases write protection, waits out the protection setup time, and issues the six command writes that unlock the device and request a full erase. It then waits out the protection hold time and polls the device with back-to-back reads until the busy-toggle bit stops changing.

The outcome is reported as a one-cycle `done_o` or `err_o` pulse. An error means the poll budget ran out. The secondary status bit seen on the last poll read is kept on `dq2_stat_o`.

All bus timing is set in clock cycles through parameters: setup, strobe pulse, hold, read recovery and the write-protect margin. A parameter chooses whether a write is strobed by the write enable or by the chip enable. Another parameter sets the top address bit, which is 19 or 20 depending on the flash density.

Top module: `nor_erase_seq`

## Requirements
- R1: After a start, exactly six bus writes are issued, in this order of (address, low data byte): (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x10). A device that checks this order accepts it as an erase, and a sequence with any corrupted write is not accepted.
- R2: In every command write, data bits 15:8 are driven to 0. The command value sits in bits 7:0.
- R3: The flash address is ADDR_MSB+1 bits wide. Command addresses are zero-extended to that width.
- R4: The write strobe (write enable and chip enable both low) stays low for at least T_PULSE cycles. Address and data are valid T_SETUP cycles before the strobe falls and stay unchanged until T_HOLD cycles after it rises.
- R5: The output enable stays high whenever the data bus is driven. Between two poll reads, the output enable stays high for at least T_RECOV cycles.
- R6: With STROBE_CE=0, the write enable forms the write pulse while the chip enable stays low around it, so the write ends on the write-enable rising edge. With STROBE_CE=1, the chip enable forms the pulse instead.
- R7: `flash_wp_n_o` is high (unprotected) for at least T_WPHOLD cycles before the first write strobe. It stays high through every write and for at least T_WPHOLD cycles after the last one. It is low while idle.
- R8: Polling reads DQ6 (bit 6) repeatedly. The erase is complete when two consecutive reads return the same DQ6, and `done_o` then pulses. If the device toggles DQ6 for N reads, exactly N+2 reads are made.
- R9: If no match is found by the MAX_POLLS-th read, `err_o` pulses and polling stops after exactly MAX_POLLS reads. A match on the MAX_POLLS-th read itself counts as completion.
- R10: `dq2_stat_o` holds DQ2 (bit 2) from the most recent poll read.
- R11: `busy_o` rises the cycle after an accepted start. A start while busy is ignored. `done_o` or `err_o` lasts one cycle, and the block is idle in the next cycle.
- R12: After reset the block is idle, with chip enable, write enable and output enable high, write protect low, and the data bus not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a chip erase (sampled while idle) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: erase completed |
| err_o | output | 1 | One-cycle pulse: poll budget exhausted |
| dq2_stat_o | output | 1 | DQ2 captured on the latest poll read |
| flash_addr_o | output | ADDR_MSB+1 | Flash address |
| flash_dq_i | input | 16 | Flash data read back |
| flash_dq_o | output | 16 | Flash data to write |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_wp_n_o | output | 1 | Write protect, active low |

## Verification
Completion detection and the poll-limit expiry can both fall on the same read acknowledge. This happens when the device stops toggling exactly on the MAX_POLLS-th read. The bench provokes it with a device stub that toggles MAX_POLLS-2 times, where completion must win with a `done_o` and MAX_POLLS reads. One toggle more must produce `err_o` after the same number of reads. A second start pulse in the middle of an operation tests that the ignore-while-busy rule holds while the sequencer is busy: the write count must stay at six and only one outcome pulse may appear.

// File: rtl/nor_erase_pkg.sv
// Package: shared state encodings and the chip-erase command table.
// Assumes a 16-bit data bus; command addresses fit in 16 bits.
package nor_erase_pkg;

    localparam int CMD_LEN = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WP_PRE,
        S_CMD,
        S_WP_POST,
        S_POLL,
        S_FIN
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WSTRB,
        PH_HOLD,
        PH_RSTRB,
        PH_RECOV
    } bus_phase_t;

    // Address of command write number idx (0..5)
    function automatic logic [15:0] cmd_addr(input logic [2:0] idx);
        case (idx)
            3'd1, 3'd4: cmd_addr = 16'h2AAA;
            default:    cmd_addr = 16'h5555;
        endcase
    endfunction

    // Low data byte of command write number idx (0..5)
    function automatic logic [7:0] cmd_data(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd3: cmd_data = 8'hAA;
            3'd1, 3'd4: cmd_data = 8'h55;
            3'd2:       cmd_data = 8'h80;
            3'd5:       cmd_data = 8'h10;
            default:    cmd_data = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
// Module: nor_bus_cycle
// Runs one flash bus cycle per go pulse: either a write (setup, strobe,
// hold) or a read (output-enable strobe, then recovery with OE high).
// Pulses ack_o for one cycle when the cycle, including recovery, ends.
// Assumes all timing parameters are at least 1 and that go_i is only
// raised while no cycle is in flight.
module nor_bus_cycle
    import nor_erase_pkg::*;
#(
    parameter int AW        = 21,
    parameter int T_SETUP   = 1,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 1,
    parameter int T_RECOV   = 2,
    parameter bit STROBE_CE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [15:0]   wdata_i,
    input  logic [15:0]   dq_i,
    output logic          ack_o,
    output logic [15:0]   rdata_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [15:0]   bus_dq_o,
    output logic          bus_dq_oe_o,
    output logic          bus_ce_n_o,
    output logic          bus_we_n_o,
    output logic          bus_oe_n_o
);

    localparam int T_A  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int T_B  = (T_HOLD > T_RECOV) ? T_HOLD : T_RECOV;
    localparam int TMAX = (T_A > T_B) ? T_A : T_B;
    localparam int CW   = $clog2(TMAX + 1);

    bus_phase_t    ph;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_r;
    logic [15:0]   data_r;
    logic          wr_act;
    logic          wstrb;
    logic          rstrb;

    // Phase sequencer: steps through the phases of one bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            ack_o   <= 1'b0;
            addr_r  <= '0;
            data_r  <= '0;
            rdata_o <= '0;
        end else begin
            ack_o <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (go_i) begin
                        addr_r <= addr_i;
                        data_r <= wdata_i;
                        if (rd_i) begin
                            ph  <= PH_RSTRB;
                            cnt <= CW'(T_PULSE - 1);
                        end else begin
                            ph  <= PH_SETUP;
                            cnt <= CW'(T_SETUP - 1);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_WSTRB;
                        cnt <= CW'(T_PULSE - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WSTRB: begin
                    if (cnt == '0) begin
                        ph  <= PH_HOLD;
                        cnt <= CW'(T_HOLD - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        ph    <= PH_IDLE;
                        ack_o <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RSTRB: begin
                    if (cnt == '0) begin
                        rdata_o <= dq_i;
                        ph      <= PH_RECOV;
                        cnt     <= CW'(T_RECOV - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt == '0) begin
                        ph    <= PH_IDLE;
                        ack_o <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Phase decode shared by both strobe modes
    always_comb begin
        wr_act = (ph == PH_SETUP) || (ph == PH_WSTRB) || (ph == PH_HOLD);
        wstrb  = (ph == PH_WSTRB);
        rstrb  = (ph == PH_RSTRB);
    end

    // Strobe-mode variant: which pin forms the write pulse
    generate
        if (STROBE_CE) begin : g_ce_strobe
            assign bus_ce_n_o = !(wstrb || rstrb);
            assign bus_we_n_o = !wr_act;
        end else begin : g_we_strobe
            assign bus_ce_n_o = !(wr_act || rstrb);
            assign bus_we_n_o = !wstrb;
        end
    endgenerate

    assign bus_oe_n_o  = !rstrb;
    assign bus_dq_oe_o = wr_act;
    assign bus_dq_o    = data_r;
    assign bus_addr_o  = addr_r;

endmodule

// File: rtl/nor_poll_judge.sv
// Module: nor_poll_judge
// Judges toggle-bit poll reads: a hit when DQ6 equals the previous read,
// an expiry when the budget is spent without a hit. Hit takes priority.
// Also keeps DQ2 from the latest read. Assumes MAX_POLLS >= 2.
module nor_poll_judge #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic rd_vld_i,
    input  logic dq6_i,
    input  logic dq2_i,
    output logic hit_o,
    output logic expire_o,
    output logic dq2_o
);

    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt;
    logic          seen;
    logic          prev;

    // Decision for the read being acknowledged in this cycle
    always_comb begin
        hit_o    = rd_vld_i && seen && (dq6_i == prev);
        expire_o = rd_vld_i && !hit_o && (cnt == PW'(MAX_POLLS - 1));
    end

    // History of the previous read and the read count
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt   <= '0;
            seen  <= 1'b0;
            prev  <= 1'b0;
            dq2_o <= 1'b0;
        end else if (rd_vld_i) begin
            cnt   <= cnt + 1'b1;
            seen  <= 1'b1;
            prev  <= dq6_i;
            dq2_o <= dq2_i;
        end
    end

endmodule

// File: rtl/nor_erase_seq.sv
// Module: nor_erase_seq (top)
// Full-chip erase sequencer: write-protect margin, six command writes,
// write-protect margin, toggle-bit polling, one-cycle done/error report.
// Assumes 16 <= ADDR_MSB+1 and all timing parameters >= 1.
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int ADDR_MSB  = 20,
    parameter bit STROBE_CE = 1'b0,
    parameter int T_SETUP   = 1,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 1,
    parameter int T_RECOV   = 2,
    parameter int T_WPHOLD  = 100,
    parameter int MAX_POLLS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                dq2_stat_o,
    output logic [ADDR_MSB:0]   flash_addr_o,
    input  logic [15:0]         flash_dq_i,
    output logic [15:0]         flash_dq_o,
    output logic                flash_dq_oe_o,
    output logic                flash_ce_n_o,
    output logic                flash_oe_n_o,
    output logic                flash_we_n_o,
    output logic                flash_wp_n_o
);

    localparam int AW  = ADDR_MSB + 1;
    localparam int WCW = $clog2(T_WPHOLD + 1);

    seq_state_t     state;
    logic [WCW-1:0] wcnt;
    logic [2:0]     idx;
    logic           inflight;
    logic           ok_r;
    logic           go;
    logic           ack;
    logic           rd_vld;
    logic           hit;
    logic           expire;
    logic           clr;
    logic [AW-1:0]  cyc_addr;
    logic [15:0]    cyc_data;
    logic [15:0]    rdata;
    logic           unused_rdata;

    // Request generation toward the bus-cycle engine
    always_comb begin
        go       = ((state == S_CMD) || (state == S_POLL)) && !inflight;
        cyc_addr = (state == S_CMD) ? AW'(cmd_addr(idx)) : '0;
        cyc_data = {8'h00, cmd_data(idx)};
        rd_vld   = ack && (state == S_POLL);
        clr      = (state == S_IDLE) && start_i;
    end

    // Main sequence: margins, command writes, polling, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wcnt     <= '0;
            idx      <= '0;
            inflight <= 1'b0;
            ok_r     <= 1'b0;
        end else begin
            if (go) begin
                inflight <= 1'b1;
            end else if (ack) begin
                inflight <= 1'b0;
            end
            case (state)
                S_IDLE: begin
                    if (start_i) begin
                        state <= S_WP_PRE;
                        wcnt  <= WCW'(T_WPHOLD - 1);
                        idx   <= '0;
                        ok_r  <= 1'b0;
                    end
                end
                S_WP_PRE: begin
                    if (wcnt == '0) begin
                        state <= S_CMD;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                S_CMD: begin
                    if (ack) begin
                        if (idx == 3'(CMD_LEN - 1)) begin
                            state <= S_WP_POST;
                            wcnt  <= WCW'(T_WPHOLD - 1);
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_WP_POST: begin
                    if (wcnt == '0) begin
                        state <= S_POLL;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                S_POLL: begin
                    if (hit) begin
                        state <= S_FIN;
                        ok_r  <= 1'b1;
                    end else if (expire) begin
                        state <= S_FIN;
                        ok_r  <= 1'b0;
                    end
                end
                S_FIN: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outcome and status outputs
    always_comb begin
        busy_o       = (state != S_IDLE);
        done_o       = (state == S_FIN) && ok_r;
        err_o        = (state == S_FIN) && !ok_r;
        flash_wp_n_o = (state != S_IDLE);
        unused_rdata = ^{rdata[15:7], rdata[5:3], rdata[1:0]};
    end

    nor_bus_cycle #(
        .AW        (AW),
        .T_SETUP   (T_SETUP),
        .T_PULSE   (T_PULSE),
        .T_HOLD    (T_HOLD),
        .T_RECOV   (T_RECOV),
        .STROBE_CE (STROBE_CE)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .rd_i        (state == S_POLL),
        .addr_i      (cyc_addr),
        .wdata_i     (cyc_data),
        .dq_i        (flash_dq_i),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .bus_addr_o  (flash_addr_o),
        .bus_dq_o    (flash_dq_o),
        .bus_dq_oe_o (flash_dq_oe_o),
        .bus_ce_n_o  (flash_ce_n_o),
        .bus_we_n_o  (flash_we_n_o),
        .bus_oe_n_o  (flash_oe_n_o)
    );

    nor_poll_judge #(
        .MAX_POLLS (MAX_POLLS)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clr),
        .rd_vld_i (rd_vld),
        .dq6_i    (rdata[6]),
        .dq2_i    (rdata[2]),
        .hit_o    (hit),
        .expire_o (expire),
        .dq2_o    (dq2_stat_o)
    );

endmodule

// File: rtl/nor_erase_seq_chk.sv
// Module: nor_erase_seq_chk
// Protocol checker bound to nor_erase_seq: strobe discipline, protect
// window, output-enable use and the outcome handshake.
module nor_erase_seq_chk #(
    parameter int ADDR_MSB = 20,
    parameter int T_PULSE  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_MSB:0] flash_addr_o,
    input logic [15:0]       flash_dq_o,
    input logic              flash_dq_oe_o,
    input logic              flash_ce_n_o,
    input logic              flash_oe_n_o,
    input logic              flash_we_n_o,
    input logic              flash_wp_n_o
);

    logic        wlow;
    logic [15:0] lowc;

    assign wlow = !flash_we_n_o && !flash_ce_n_o;

    // Count consecutive cycles of an active write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lowc <= '0;
        end else begin
            lowc <= wlow ? lowc + 1'b1 : '0;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (!wlow && $past(wlow)) |-> (lowc >= 16'(T_PULSE))); // R4
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (wlow && $past(wlow)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o))); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) flash_dq_oe_o |-> (flash_dq_o[15:8] == 8'h00)); // R2
    AST_OE_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) flash_dq_oe_o |-> flash_oe_n_o); // R5
    AST_WP_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wlow |-> flash_wp_n_o); // R7
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o)); // R9
    AST_OUTCOME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (done_o || err_o) |=> (!done_o && !err_o && !busy_o)); // R11
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && start_i) |=> busy_o); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (flash_ce_n_o && flash_we_n_o && flash_oe_n_o && !flash_wp_n_o)); // R12

endmodule

bind nor_erase_seq nor_erase_seq_chk #(
    .ADDR_MSB (ADDR_MSB),
    .T_PULSE  (T_PULSE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .flash_addr_o  (flash_addr_o),
    .flash_dq_o    (flash_dq_o),
    .flash_dq_oe_o (flash_dq_oe_o),
    .flash_ce_n_o  (flash_ce_n_o),
    .flash_oe_n_o  (flash_oe_n_o),
    .flash_we_n_o  (flash_we_n_o),
    .flash_wp_n_o  (flash_wp_n_o)
);

// File: tb/nor_erase_seq_bench.sv
// Behavioural flash stub: checks the erase command order, toggles DQ6 for
// a set number of reads after an accepted erase, and measures bus timing.
module flash_stub #(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          wp_n,
    input  logic          dq2_lvl,
    input  int            toggles,
    output logic [15:0]   dq_r
);
    int n_wr, n_rd, step, left, min_pw, min_gap, wp_pre, wp_post;
    int low_cnt, hi_cnt, wp_hi, since_wr;
    bit erased, tog, stab_bad, edge_bad, oe_bad, wp_bad;
    bit prev_ws, prev_rs, prev_wp, ws, rs;
    logic [AW-1:0] fa;
    logic [15:0]   fd;
    logic [AW-1:0] la [8];
    logic [15:0]   ld [8];

    function automatic logic [15:0] sa(input int i);
        return (i == 1 || i == 4) ? 16'h2AAA : 16'h5555;
    endfunction
    function automatic logic [7:0] sd(input int i);
        case (i)
            0, 3:    return 8'hAA;
            1, 4:    return 8'h55;
            2:       return 8'h80;
            default: return 8'h10;
        endcase
    endfunction

    assign dq_r = {9'h000, tog, 3'b000, dq2_lvl, 2'b00};

    always @(posedge clk) begin
        ws = we_n | ce_n;
        rs = oe_n | ce_n;
        if (!rst_n || clr) begin
            n_wr = 0; n_rd = 0; step = 0; left = 0; erased = 0; tog = 0;
            min_pw = 9999; min_gap = 9999; wp_pre = -1; wp_post = -1;
            low_cnt = 0; hi_cnt = 0; wp_hi = 0; since_wr = 0;
            stab_bad = 0; edge_bad = 0; oe_bad = 0; wp_bad = 0;
        end else begin
            if (wp_n) wp_hi++; else wp_hi = 0;
            since_wr++;
            if (prev_wp && !wp_n && n_wr > 0) wp_post = since_wr;
            if (!ws) low_cnt++;
            if (!ws && !wp_n) wp_bad = 1;
            if (prev_ws && !ws) begin
                fa = addr; fd = dq;
                if (n_wr == 0) wp_pre = wp_hi;
            end
            if (!prev_ws && ws) begin
                if (low_cnt < min_pw) min_pw = low_cnt;
                low_cnt = 0;
                if (addr != fa || dq != fd) stab_bad = 1;
                if (ce_n) edge_bad = 1;
                if (!oe_n) oe_bad = 1;
                if (n_wr < 8) begin la[n_wr] = addr; ld[n_wr] = dq; end
                if (addr == AW'(sa(step)) && dq[7:0] == sd(step)) step++;
                else step = 0;
                if (step == 6) begin erased = 1; left = toggles; step = 0; end
                n_wr++;
                since_wr = 0;
            end
            if (rs) hi_cnt++;
            if (prev_rs && !rs && n_rd > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
            if (!prev_rs && rs) begin
                n_rd++;
                hi_cnt = 1;
                if (left > 0) begin tog = ~tog; left--; end
            end
        end
        prev_ws = ws;
        prev_rs = rs;
        prev_wp = wp_n;
    end
endmodule

// Bench: random and directed erase operations against the stub.
module nor_erase_seq_bench;
    localparam int ADDR_MSB  = 20;
    localparam int AW        = ADDR_MSB + 1;
    localparam int T_PULSE   = 3;
    localparam int T_RECOV   = 2;
    localparam int T_WPHOLD  = 100;
    localparam int MAX_POLLS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic clr = 1'b0;
    logic dq2_lvl = 1'b0;
    int   toggles = 0;
    int   corrupt_idx = -1;
    int   checks = 0;
    int   fails = 0;
    int   total = 0;

    logic          busy, done, err, dq2_stat, dq_oe, ce_n, oe_n, we_n, wp_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_o, dq_i, stub_dq_in;

    always #5 clk = ~clk;

    nor_erase_seq #(
        .ADDR_MSB  (ADDR_MSB),
        .T_PULSE   (T_PULSE),
        .T_RECOV   (T_RECOV),
        .T_WPHOLD  (T_WPHOLD),
        .MAX_POLLS (MAX_POLLS)
    ) u_nor_erase_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .busy_o (busy), .done_o (done), .err_o (err), .dq2_stat_o (dq2_stat),
        .flash_addr_o (addr), .flash_dq_i (dq_i), .flash_dq_o (dq_o),
        .flash_dq_oe_o (dq_oe), .flash_ce_n_o (ce_n), .flash_oe_n_o (oe_n),
        .flash_we_n_o (we_n), .flash_wp_n_o (wp_n)
    );

    flash_stub #(.AW (AW)) u_stub (
        .clk (clk), .rst_n (rst_n), .clr (clr), .addr (addr), .dq (stub_dq_in),
        .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n), .wp_n (wp_n),
        .dq2_lvl (dq2_lvl), .toggles (toggles), .dq_r (dq_i)
    );

    assign stub_dq_in = dq_o ^ {15'h0000, (corrupt_idx >= 0) && (u_stub.n_wr == corrupt_idx)};

    function automatic logic [AW-1:0] exp_addr(input int i);
        return (i == 1 || i == 4) ? AW'(16'h2AAA) : AW'(16'h5555);
    endfunction
    function automatic logic [7:0] exp_data(input int i);
        logic [7:0] t [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        return t[i];
    endfunction
    function automatic int exp_reads(input int tg, input int cidx);
        if (cidx >= 0) return 2;
        return (tg + 2 <= MAX_POLLS) ? tg + 2 : MAX_POLLS;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int tg, input int cidx, input bit d2, input bit poke);
        int  cyc;
        int  outcomes;
        bit  got_done;
        bit  exp_ok;
        toggles     = tg;
        corrupt_idx = cidx;
        dq2_lvl     = d2;
        clr = 1'b1;
        @(negedge clk);
        clr   = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
        cyc = 0;
        outcomes = 0;
        while (!(done || err) && cyc < 20000) begin
            start = poke && (cyc == 40);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 20000) begin
            chk(1'b0, "R8", "operation never ended", cyc, 0);
            return;
        end
        got_done = done;
        outcomes = 1;
        exp_ok = (cidx >= 0) ? 1'b1 : (tg + 2 <= MAX_POLLS);
        chk(got_done == exp_ok, exp_ok ? "R8" : "R9", "done vs err", got_done, exp_ok);
        chk(dq2_stat == d2, "R10", "dq2 status", dq2_stat, d2);
        @(negedge clk);
        chk(!done && !err && !busy, "R11", "outcome one cycle then idle", {done, err, busy}, 0);
        repeat (20) begin
            @(negedge clk);
            if (done || err) outcomes++;
        end
        chk(outcomes == 1 && !busy, "R11", "single outcome, no restart", outcomes, 1);
        chk(u_stub.n_rd == exp_reads(tg, cidx), exp_ok ? "R8" : "R9", "poll reads",
            u_stub.n_rd, exp_reads(tg, cidx));
        chk(u_stub.n_wr == 6, "R1", "write count", u_stub.n_wr, 6);
        chk(u_stub.erased == (cidx < 0), "R1", "stub accepted erase", u_stub.erased, cidx < 0);
        if (cidx < 0) begin
            for (int i = 0; i < 6; i++) begin
                chk(u_stub.ld[i][7:0] == exp_data(i), "R1", "command data", u_stub.ld[i][7:0], exp_data(i));
                chk(u_stub.la[i] == exp_addr(i), "R3", "command address", u_stub.la[i], exp_addr(i));
                chk(u_stub.ld[i][15:8] == 8'h00, "R2", "upper byte", u_stub.ld[i][15:8], 0);
            end
        end
        chk(u_stub.min_pw >= T_PULSE, "R4", "write pulse width", u_stub.min_pw, T_PULSE);
        chk(!u_stub.stab_bad, "R4", "addr/data stable across strobe", u_stub.stab_bad, 0);
        chk(!u_stub.oe_bad, "R5", "OE high at write edge", u_stub.oe_bad, 0);
        if (u_stub.n_rd > 1)
            chk(u_stub.min_gap >= T_RECOV, "R5", "read recovery", u_stub.min_gap, T_RECOV);
        chk(!u_stub.edge_bad, "R6", "write ends on WE edge with CE low", u_stub.edge_bad, 0);
        chk(u_stub.wp_pre >= T_WPHOLD, "R7", "protect lead time", u_stub.wp_pre, T_WPHOLD);
        chk(u_stub.wp_post >= T_WPHOLD, "R7", "protect trail time", u_stub.wp_post, T_WPHOLD);
        chk(!u_stub.wp_bad, "R7", "protect high during writes", u_stub.wp_bad, 0);
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised
    always @(posedge clk) begin
        total++;
        if (total > 190000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", total, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        // R12 reset state, sampled while reset is still held
        chk(!busy && !done && !err, "R12", "status in reset", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && we_n && oe_n && !wp_n && !dq_oe, "R12", "bus idle after reset",
            {ce_n, we_n, oe_n, wp_n, dq_oe}, 5'b11100);
        run_op(0, -1, 1'b1, 1'b0);               // R8 immediate stability
        run_op(MAX_POLLS - 2, -1, 1'b0, 1'b0);   // R9 match on the last permitted read
        run_op(MAX_POLLS - 1, -1, 1'b1, 1'b0);   // R9 budget exhausted
        run_op(3, 2, 1'b0, 1'b0);                // R1 corrupted third write
        run_op(4, -1, 1'b1, 1'b1);               // R11 start while busy
        for (int k = 0; k < 5; k++) begin
            run_op(int'($urandom_range(0, 10)), -1, 1'($urandom % 2), 1'($urandom % 2));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule